// File: doc/BRIEF.md
# ADC Data-Ready Indicator Generator

This block drives the active-low data-ready indication of a multichannel sampling converter. It watches three events. The first is a single-cycle strobe that marks a finished conversion. The second is a level that is high while the host is clocking a frame out of the serial port. The third is a single-cycle strobe that marks the moment the last conversion bit of a result has left the device. From these it produces the data-ready level and a separate output-enable, which the pad ring uses to emulate an open-drain pin.

Two mode inputs shape the indication. The format bit selects between a held level and a short negative pulse. In level format the line falls when a result is ready and rises when that result has been shifted out. When a new result arrives before the old one was read, the line rises for one cycle and then falls again. In pulse format each result is marked by a low pulse of a parameterised width. Pulses are suppressed while a frame is being read. A result that follows an unread pulse gets no pulse, so an idle host sees every second result. The drive bit selects push-pull or released-high (open-drain) behaviour.

Everything runs on the master clock. The reset is asynchronous active-low, and its release is synchronised inside the block.

Top module: `drdy_gen`

## Requirements
- R1: After reset is released (two clock cycles of internal synchronisation), drdy_n is 1 and no result is pending, so the first accepted conversion in pulse format produces a pulse.
- R2: In level format (fmt_pulse=0), a conv_done while drdy_n is high makes drdy_n 0 from the next cycle on. It stays 0 until a cycle in which shift_done is 1 without conv_done, and it is 1 in the cycle after that one.
- R3: In level format, a conv_done while drdy_n is 0 makes drdy_n 1 for exactly one cycle, and then 0 again.
- R4: In pulse format (fmt_pulse=1), an accepted conv_done makes drdy_n 0 for exactly PULSE_W cycles, starting the cycle after the strobe. drdy_n never falls without a conv_done.
- R5: In pulse format, if no shift_done arrives after a pulse, the next conv_done produces no pulse and the one after it produces a pulse again.
- R6: In pulse format, a shift_done after a pulse clears the pending state, so the next conv_done produces a pulse.
- R7: In pulse format, a conv_done while frame_busy is 1 produces no pulse and leaves the pending state unchanged.
- R8: With drive_od=0, drdy_oe is always 1. With drive_od=1, drdy_oe is 1 exactly when drdy_n is 0.
- R9: In level format, when conv_done and shift_done fall in the same cycle, conv_done wins: the line shows the one-cycle high gap of R3 and then stays low.
- R10: Switching fmt_pulse clears the state of the format that was left, so drdy_n is 1 in the cycle after the switch unless a conversion is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a new conversion result is ready |
| frame_busy | input | 1 | High while a serial frame is being read |
| shift_done | input | 1 | One-cycle strobe: all conversion data of the result has been shifted out |
| fmt_pulse | input | 1 | Format select: 0 held level, 1 short pulse |
| drive_od | input | 1 | Drive select: 0 push-pull, 1 released high |
| drdy_n | output | 1 | Data-ready indication, active low |
| drdy_oe | output | 1 | Output enable for the pin driver |

## Verification
The bench targets the skip sequence after an unread pulse; a design without the pending flag would pulse on every result. It also sends a conversion while a frame is being read, to show that the blocked result neither pulses nor clears the pending state; a design that cleared it would pulse on the very next result. The level-format overrun gap and the tie between a conversion and shift completion are driven directly; a design that gave the read priority would leave the line high. Long random runs in all four mode combinations, with format switches between them, are compared cycle by cycle against a reference model, which catches wrong pulse widths and open-drain enables that follow the wrong polarity.

// File: rtl/drdy_pkg.sv
package drdy_pkg;

  typedef enum logic [1:0] {
    LV_IDLE = 2'd0,
    LV_LOW  = 2'd1,
    LV_GAP  = 2'd2
  } lvl_state_t;

  function automatic int unsigned cnt_width(input int unsigned w);
    return (w < 2) ? 1 : $clog2(w + 1);
  endfunction

endpackage

// File: rtl/drdy_level_seq.sv
module drdy_level_seq
  import drdy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic conv_done,
  input  logic shift_done,
  output logic low_req
);

  lvl_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!en) begin
      st_d = LV_IDLE;
    end else begin
      unique case (st_q)
        LV_IDLE: if (conv_done) st_d = LV_LOW;
        LV_LOW: begin
          if (conv_done)       st_d = LV_GAP;
          else if (shift_done) st_d = LV_IDLE;
        end
        LV_GAP:  st_d = LV_LOW;
        default: st_d = LV_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LV_IDLE;
    else        st_q <= st_d;
  end

  assign low_req = (st_q == LV_LOW);

endmodule

// File: rtl/drdy_pulse_seq.sv
module drdy_pulse_seq
  import drdy_pkg::*;
#(
  parameter int unsigned PULSE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic conv_done,
  input  logic frame_busy,
  input  logic shift_done,
  output logic low_req
);

  localparam int unsigned CW = cnt_width(PULSE_W);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_W);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          pend_eff, accept, fire, skip;

  always_comb begin
    pend_eff = pend_q & ~shift_done;
    accept   = conv_done & ~frame_busy;
    fire     = accept & ~pend_eff;
    skip     = accept & pend_eff;

    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (!en) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else begin
      if (fire)              cnt_d = LOAD;
      else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;

      if (fire)       pend_d = 1'b1;
      else if (skip)  pend_d = 1'b0;
      else            pend_d = pend_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign low_req = (cnt_q != '0);

endmodule

// File: rtl/drdy_pin_drive.sv
module drdy_pin_drive (
  input  logic low_req,
  input  logic drive_od,
  output logic pin_n,
  output logic pin_oe
);

  always_comb begin
    pin_n  = ~low_req;
    pin_oe = ~drive_od | low_req;
  end

endmodule

// File: rtl/drdy_gen.sv
module drdy_gen #(
  parameter int unsigned PULSE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  logic frame_busy,
  input  logic shift_done,
  input  logic fmt_pulse,
  input  logic drive_od,
  output logic drdy_n,
  output logic drdy_oe
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       lvl_low, pls_low, low_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  drdy_level_seq u_lvl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .en         (~fmt_pulse),
    .conv_done  (conv_done),
    .shift_done (shift_done),
    .low_req    (lvl_low)
  );

  drdy_pulse_seq #(.PULSE_W(PULSE_W)) u_pls (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .en         (fmt_pulse),
    .conv_done  (conv_done),
    .frame_busy (frame_busy),
    .shift_done (shift_done),
    .low_req    (pls_low)
  );

  assign low_sel = fmt_pulse ? pls_low : lvl_low;

  drdy_pin_drive u_pin (
    .low_req  (low_sel),
    .drive_od (drive_od),
    .pin_n    (drdy_n),
    .pin_oe   (drdy_oe)
  );

endmodule

// File: rtl/drdy_gen_chk.sv
module drdy_gen_chk (
  input logic clk,
  input logic rst_n_int,
  input logic conv_done,
  input logic frame_busy,
  input logic shift_done,
  input logic fmt_pulse,
  input logic drive_od,
  input logic drdy_n,
  input logic drdy_oe
);

  a_r8_push_pull_oe: assert property (@(posedge clk) disable iff (!rst_n_int)
    !drive_od |-> drdy_oe);

  a_r8_od_released: assert property (@(posedge clk) disable iff (!rst_n_int)
    drive_od |-> (drdy_oe == !drdy_n));

  a_r2_level_fall: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!fmt_pulse && conv_done && drdy_n) |=> (fmt_pulse || !drdy_n));

  a_r2_level_release: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!fmt_pulse && shift_done && !conv_done && !drdy_n) |=> (fmt_pulse || drdy_n));

  a_r3_level_gap: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!fmt_pulse && conv_done && !drdy_n) |=> (fmt_pulse || drdy_n));

  a_r4_no_spurious_fall: assert property (@(posedge clk) disable iff (!rst_n_int)
    (fmt_pulse && drdy_n && !conv_done) |=> (!fmt_pulse || drdy_n));

  a_r7_blocked_in_read: assert property (@(posedge clk) disable iff (!rst_n_int)
    (fmt_pulse && drdy_n && conv_done && frame_busy) |=> (!fmt_pulse || drdy_n));

endmodule

bind drdy_gen drdy_gen_chk u_chk (
  .clk        (clk),
  .rst_n_int  (rst_n_int),
  .conv_done  (conv_done),
  .frame_busy (frame_busy),
  .shift_done (shift_done),
  .fmt_pulse  (fmt_pulse),
  .drive_od   (drive_od),
  .drdy_n     (drdy_n),
  .drdy_oe    (drdy_oe)
);

// File: tb/sim_drdy_gen.sv
`timescale 1ns/1ps
module sim_drdy_gen;

  localparam int unsigned PW = 2;

  logic clk, rst_n;
  logic conv_done, frame_busy, shift_done, fmt_pulse, drive_od;
  logic drdy_n, drdy_oe;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  drdy_gen #(.PULSE_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .frame_busy(frame_busy),
    .shift_done(shift_done), .fmt_pulse(fmt_pulse), .drive_od(drive_od),
    .drdy_n(drdy_n), .drdy_oe(drdy_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model, written from the requirements
  int  m_lvl;   // 0 idle-high, 1 low, 2 one-cycle gap
  bit  m_pend;
  int  m_cnt;
  bit  m_rst;

  function automatic bit model_low(input bit fmt, input int lvl, input int cnt);
    return fmt ? (cnt > 0) : (lvl == 1);
  endfunction

  function automatic bit exp_oe(input bit od, input bit low);
    return !od || low;
  endfunction

  always @(posedge clk) begin
    if (m_rst) begin
      m_lvl = 0; m_pend = 0; m_cnt = 0;
    end else if (!fmt_pulse) begin
      m_pend = 0; m_cnt = 0;
      if (m_lvl == 2) m_lvl = 1;
      else if (m_lvl == 1) begin
        if (conv_done) m_lvl = 2;
        else if (shift_done) m_lvl = 0;
      end else if (conv_done) m_lvl = 1;
    end else begin
      bit p;
      m_lvl = 0;
      p = m_pend && !shift_done;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (conv_done && !frame_busy) begin
        if (p) p = 0;
        else begin p = 1; m_cnt = PW; end
      end
      m_pend = p;
    end
  end

  task automatic chk(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input logic c, input logic b, input logic d);
    conv_done = c; frame_busy = b; shift_done = d;
    @(negedge clk);
  endtask

  task automatic do_reset();
    m_rst = 1; rst_n = 0;
    conv_done = 0; frame_busy = 0; shift_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_rst = 0;
  endtask

  task automatic rand_run(input bit fmt, input bit od, input int n);
    fmt_pulse = fmt; drive_od = od;
    for (int i = 0; i < n; i++) begin
      step(($urandom % 6) == 0, ($urandom % 4) == 0, ($urandom % 5) == 0);
      chk("R2/R4 model drdy_n", drdy_n, !model_low(fmt, m_lvl, m_cnt));
      chk("R8 model drdy_oe", drdy_oe, exp_oe(od, model_low(fmt, m_lvl, m_cnt)));
    end
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    fmt_pulse = 0; drive_od = 0;
    do_reset();
    chk("R1 reset drdy_n", drdy_n, 1'b1);
    chk("R1 reset oe", drdy_oe, 1'b1);

    // Level format
    step(1,0,0); chk("R2 fall", drdy_n, 1'b0);
    step(0,0,0); step(0,1,0); step(0,0,0); chk("R2 held low", drdy_n, 1'b0);
    step(0,0,1); chk("R2 release", drdy_n, 1'b1);
    step(0,0,0); chk("R2 stays high", drdy_n, 1'b1);
    step(1,0,0); chk("R3 low", drdy_n, 1'b0);
    step(1,0,0); chk("R3 gap high", drdy_n, 1'b1);
    step(0,0,0); chk("R3 low again", drdy_n, 1'b0);
    step(1,0,1); chk("R9 tie gap", drdy_n, 1'b1);
    step(0,0,0); chk("R9 tie low", drdy_n, 1'b0);
    step(0,0,0); chk("R9 still low", drdy_n, 1'b0);

    // Switch to pulse format while level is low
    fmt_pulse = 1;
    step(0,0,0); chk("R10 switch clears", drdy_n, 1'b1);

    // Pulse format (R1: nothing pending after reset/switch)
    step(1,0,0); chk("R4 pulse c1", drdy_n, 1'b0);
    step(0,0,0); chk("R4 pulse c2", drdy_n, 1'b0);
    step(0,0,0); chk("R4 pulse end", drdy_n, 1'b1);
    step(1,0,0); chk("R5 skipped", drdy_n, 1'b1);
    step(0,0,0); chk("R5 skipped hold", drdy_n, 1'b1);
    step(1,0,0); chk("R5 next pulses", drdy_n, 1'b0);
    step(0,0,0); step(0,0,0);
    step(0,0,1);
    step(1,0,0); chk("R6 read then pulse", drdy_n, 1'b0);
    step(0,0,0); step(0,0,0); chk("R6 end", drdy_n, 1'b1);
    // unread pending; blocked conversion must keep it
    step(1,1,0); chk("R7 blocked", drdy_n, 1'b1);
    step(1,0,0); chk("R7 pending kept skip", drdy_n, 1'b1);
    step(1,0,0); chk("R7 following pulse", drdy_n, 1'b0);

    // Open-drain drive
    drive_od = 1;
    step(0,0,0); chk("R8 od low oe", drdy_oe, 1'b1);
    step(0,0,0); chk("R8 od high drdy_n", drdy_n, 1'b1);
    chk("R8 od released", drdy_oe, 1'b0);
    drive_od = 0;
    step(0,0,0); chk("R8 push-pull oe", drdy_oe, 1'b1);

    // Reset mid-pulse
    step(0,0,1); step(1,0,0);
    do_reset();
    chk("R1 reset mid-pulse", drdy_n, 1'b1);
    fmt_pulse = 1;
    step(1,0,0); chk("R1 pending cleared", drdy_n, 1'b0);
    step(0,0,0); step(0,0,0);

    // Random runs across all mode combinations
    for (int k = 0; k < 3; k++) begin
      rand_run(1'b0, 1'b0, 2000);
      rand_run(1'b1, 1'b0, 2000);
      rand_run(1'b0, 1'b1, 2000);
      rand_run(1'b1, 1'b1, 2000);
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule